// File: doc/BRIEF.md
# Clock Failure Watchdog

This block is a watchdog timer that runs from its own slow, free-running clock. It can serve as an ordinary watchdog, which software reloads with a kick. It can also be switched into a supervision mode, in which proof that the system clock is still running reloads it. The clock controller arms this mode when it starts a clock-source change. From then on the counter is reloaded each time the system clock completes a round-trip handshake with the watchdog domain. If the system clock stalls, the handshake stops, the counter runs out, and a reset request is raised.

Software changes the enable and timeout through a protected register. A first write must carry both the unlock bit and the enable bit. That write opens a short window, and only a write inside that window takes effect. Once the supervision mode is armed, no software write can turn it off. Only a system reset or a power-on reset clears it. Each expiry also sets a cause flag. The flag survives a system reset, so that code can later find out why the part restarted. Software clears the flag, and a power-on reset also clears it.

Top module: `clk_fail_wdog`

## Requirements
- R1: After power-on reset, cfgQ is 0, monActive is 0, rstReq is 0 and causeFlag is 0.
- R2: A configuration write (cfgWr with cfgWdata) changes cfgQ only while the change window is open. A write with cfgWdata[4]=1 and cfgWdata[3]=1 opens the window and leaves cfgQ unchanged.
- R3: A write with cfgWdata[4]=0 on any of the 4 sysClk edges after the opening write loads cfgQ = {cfgWdata[3] enable, cfgWdata[2:0] timeout code} and closes the window. A write on the 5th edge or later is ignored.
- R4: When enabled, unarmed and not kicked, rstReq pulses repeat every 2^(4+code) wdClk cycles. Code 0 gives 16 cycles and code 7 gives 2048.
- R5: Each kick pulse restarts the count. Kicks spaced closer than the timeout prevent any rstReq.
- R6: rstReq is high for exactly one wdClk cycle per expiry.
- R7: causeFlag goes high with rstReq. It stays high through rstN, and it is cleared by a causeClr pulse or by porN.
- R8: A monArm pulse sets monActive. While armed and sysClk runs, no rstReq occurs without kicks, even with the enable bit written to 0.
- R9: monActive is cleared only by rstN or porN. Configuration writes leave it set.
- R10: While armed, if sysClk stops, rstReq is raised within the timeout plus 8 wdClk cycles.
- R11: When unarmed with the enable bit at 0, rstReq never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Monitored system clock; register interface clock |
| wdClk | input | 1 | Independent watchdog clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | System reset, active low, asynchronous |
| cfgWr | input | 1 | Configuration write strobe (sysClk) |
| cfgWdata | input | 5 | [4] unlock, [3] enable, [2:0] timeout code |
| monArm | input | 1 | Arm clock supervision pulse (sysClk) |
| kick | input | 1 | Software reload pulse (sysClk) |
| causeClr | input | 1 | Clear cause flag pulse (sysClk) |
| cfgQ | output | 4 | Current {enable, timeout code} |
| monActive | output | 1 | Supervision mode armed |
| rstReq | output | 1 | Reset request, one wdClk cycle (wdClk) |
| causeFlag | output | 1 | Watchdog reset cause flag (wdClk) |

## Verification
The assertions assume several things about the inputs. sysClk runs at least four times faster than wdClk, so the echo handshake completes well inside the shortest timeout. Every sysClk-domain command is a single-cycle pulse. Configuration values stay stable for several wdClk cycles after a change, because each bit is synchronised on its own. Both resets are asynchronous. The bench keeps within these limits as follows. It uses a 20 ns system clock and a 100 ns watchdog clock, offset so that their edges never coincide. It drives commands as one-cycle pulses at sysClk falling edges. It waits for one expiry after each timeout change before it measures any interval, and it stops sysClk only while armed.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  // width of the timeout code field
  localparam int PRESC_W  = 3;
  // configuration write word: {unlock, enable, code}
  localparam int CFG_BITS = PRESC_W + 2;
  localparam int CE_BIT   = PRESC_W + 1;
  localparam int EN_BIT   = PRESC_W;

  // levels and toggles carried from the system domain into the watchdog domain
  typedef struct packed {
    logic               cfgEn;
    logic [PRESC_W-1:0] cfgPresc;
    logic               armed;
    logic               kickTgl;
    logic               clrTgl;
    logic               ackTgl;
  } sysStrobes_t;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfm_sys_ctrl.sv
module cfm_sys_ctrl import cfm_pkg::*; #(
  parameter int WIN_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [CFG_BITS-1:0] cfgWdata,
  input  logic                monArm,
  input  logic                kick,
  input  logic                causeClr,
  input  logic                reqTgl,
  output sysStrobes_t         strb,
  output logic [PRESC_W:0]    cfgQ,
  output logic                monActive
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic [WIN_W-1:0] winCnt;
  logic             winOpen, wrUnlock, wrCommit;
  logic [PRESC_W:0] cfgReg;
  logic             armed, kickTgl, clrTgl, ackTgl;

  always_comb begin
    winOpen  = (winCnt != '0);
    wrUnlock = cfgWr && cfgWdata[CE_BIT] && cfgWdata[EN_BIT];
    wrCommit = cfgWr && !cfgWdata[CE_BIT] && winOpen;
  end

  // change window: opened by the unlock pattern, closed by a commit or timeout
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)         winCnt <= '0;
    else if (wrUnlock) winCnt <= WIN_W'(WIN_CYCLES);
    else if (wrCommit) winCnt <= '0;
    else if (winOpen)  winCnt <= winCnt - 1'b1;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)         cfgReg <= '0;
    else if (wrCommit) cfgReg <= cfgWdata[PRESC_W:0];
  end

  // supervision arm: set by command, cleared only by reset
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)       armed <= 1'b0;
    else if (monArm) armed <= 1'b1;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      kickTgl <= 1'b0;
      clrTgl  <= 1'b0;
    end else begin
      if (kick)     kickTgl <= ~kickTgl;
      if (causeClr) clrTgl  <= ~clrTgl;
    end
  end

  // echo of the watchdog request toggle; only moves while sysClk runs
  cfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_reqSync (
    .clk (sysClk),
    .rstN(rstN),
    .d   (reqTgl),
    .q   (ackTgl)
  );

  always_comb begin
    strb.cfgEn    = cfgReg[EN_BIT];
    strb.cfgPresc = cfgReg[PRESC_W-1:0];
    strb.armed    = armed;
    strb.kickTgl  = kickTgl;
    strb.clrTgl   = clrTgl;
    strb.ackTgl   = ackTgl;
    cfgQ          = cfgReg;
    monActive     = armed;
  end

  AST_CFG_NEEDS_WIN: assert property (@(posedge sysClk) disable iff (!rstN)
    !$stable(cfgReg) |-> $past(winOpen)); // R2
  AST_WIN_LIMIT: assert property (@(posedge sysClk) disable iff (!rstN)
    winCnt <= WIN_W'(WIN_CYCLES)); // R3
  AST_ARM_STICKY: assert property (@(posedge sysClk) disable iff (!rstN)
    armed |=> armed); // R9
endmodule

// File: rtl/cfm_wd_path.sv
module cfm_wd_path import cfm_pkg::*; #(
  parameter int BASE_LOG2   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        wdClk,
  input  logic        rstN,
  input  logic        porN,
  input  sysStrobes_t sysIn,
  output logic        reqTgl,
  output logic        rstReq,
  output logic        causeFlag
);
  localparam int CNT_W = BASE_LOG2 + (1 << PRESC_W) - 1;
  localparam int BUS_W = $bits(sysStrobes_t);

  logic [BUS_W-1:0] syncBus;
  sysStrobes_t      syncd;
  logic [CNT_W-1:0] cnt, lastCnt;
  logic             kickPrev, clrPrev;
  logic             effEn, actSeen, kickEdge, clrEdge, reload, expire;

  cfm_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_busSync (
    .clk (wdClk),
    .rstN(rstN),
    .d   (sysIn),
    .q   (syncBus)
  );

  always_comb begin
    syncd    = sysStrobes_t'(syncBus);
    lastCnt  = ~({CNT_W{1'b1}} << (BASE_LOG2 + int'(syncd.cfgPresc)));
    effEn    = syncd.cfgEn | syncd.armed;
    actSeen  = (syncd.ackTgl == reqTgl);
    kickEdge = syncd.kickTgl ^ kickPrev;
    clrEdge  = syncd.clrTgl ^ clrPrev;
    reload   = kickEdge | (syncd.armed & actSeen);
    expire   = effEn & ~reload & (cnt >= lastCnt);
  end

  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      reqTgl   <= 1'b0;
      kickPrev <= 1'b0;
      clrPrev  <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      kickPrev <= syncd.kickTgl;
      clrPrev  <= syncd.clrTgl;
      rstReq   <= expire;
      if (actSeen) reqTgl <= ~reqTgl;
      if (!effEn || reload || expire) cnt <= '0;
      else                            cnt <= cnt + 1'b1;
    end
  end

  // cause flag survives system reset; only power-on clears it by reset
  always_ff @(posedge wdClk or negedge porN) begin
    if (!porN)        causeFlag <= 1'b0;
    else if (expire)  causeFlag <= 1'b1;
    else if (clrEdge) causeFlag <= 1'b0;
  end

  AST_REQ_SINGLE: assert property (@(posedge wdClk) disable iff (!rstN)
    rstReq |=> !rstReq); // R6
  AST_FLAG_FOLLOWS_REQ: assert property (@(posedge wdClk) disable iff (!rstN)
    rstReq |-> causeFlag); // R7
  AST_NO_REQ_WHEN_OFF: assert property (@(posedge wdClk) disable iff (!rstN)
    !$past(effEn) |-> !rstReq); // R11
endmodule

// File: rtl/clk_fail_wdog.sv
module clk_fail_wdog import cfm_pkg::*; #(
  parameter int BASE_LOG2   = 4,
  parameter int WIN_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                wdClk,
  input  logic                porN,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [CFG_BITS-1:0] cfgWdata,
  input  logic                monArm,
  input  logic                kick,
  input  logic                causeClr,
  output logic [PRESC_W:0]    cfgQ,
  output logic                monActive,
  output logic                rstReq,
  output logic                causeFlag
);
  logic        rstAll;
  logic        reqTgl;
  sysStrobes_t strb;

  assign rstAll = rstN & porN;

  cfm_sys_ctrl #(.WIN_CYCLES(WIN_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk   (sysClk),
    .rstN     (rstAll),
    .cfgWr    (cfgWr),
    .cfgWdata (cfgWdata),
    .monArm   (monArm),
    .kick     (kick),
    .causeClr (causeClr),
    .reqTgl   (reqTgl),
    .strb     (strb),
    .cfgQ     (cfgQ),
    .monActive(monActive)
  );

  cfm_wd_path #(.BASE_LOG2(BASE_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .wdClk    (wdClk),
    .rstN     (rstAll),
    .porN     (porN),
    .sysIn    (strb),
    .reqTgl   (reqTgl),
    .rstReq   (rstReq),
    .causeFlag(causeFlag)
  );
endmodule

// File: tb/clk_fail_wdog_test.sv
module clk_fail_wdog_test;
  logic       sysClk = 1'b0, wdClk = 1'b0, sysRun = 1'b1;
  logic       porN, rstN, cfgWr, monArm, kick, causeClr;
  logic [4:0] cfgWdata;
  logic [3:0] cfgQ;
  logic       monActive, rstReq, causeFlag;

  int nChk = 0, nFail = 0;
  int wdCycle = 0, pulseCnt = 0, lastPulse = 0;
  bit havePrev = 0, prevReq = 0, done = 0;
  int expQ[$];

  clk_fail_wdog uut (
    .sysClk(sysClk), .wdClk(wdClk), .porN(porN), .rstN(rstN),
    .cfgWr(cfgWr), .cfgWdata(cfgWdata), .monArm(monArm), .kick(kick),
    .causeClr(causeClr), .cfgQ(cfgQ), .monActive(monActive),
    .rstReq(rstReq), .causeFlag(causeFlag)
  );

  // 50 MHz system clock that can be stopped; 10 MHz watchdog clock, offset
  initial forever begin #10; if (sysRun) sysClk = ~sysClk; end
  initial begin #3; forever #50 wdClk = ~wdClk; end
  always @(posedge wdClk) wdCycle++;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    end
  endtask

  // monitor: pulse width and interval scoreboard
  always @(negedge wdClk) begin
    if (prevReq) chk("R6 rstReq width", rstReq, 0);
    if (rstReq && !prevReq) begin
      pulseCnt++;
      if (havePrev && expQ.size() > 0) chk("R4 interval", wdCycle - lastPulse, expQ.pop_front());
      lastPulse = wdCycle;
      havePrev  = 1;
    end
    prevReq = rstReq;
  end

  task automatic cfgWrite(input logic [4:0] d);
    cfgWr = 1'b1; cfgWdata = d;
    @(negedge sysClk);
    cfgWr = 1'b0; cfgWdata = '0;
  endtask

  task automatic pulseSys(ref logic sig);
    sig = 1'b1;
    @(negedge sysClk);
    sig = 1'b0;
  endtask

  task automatic waitPulse(input int maxWd, output int took);
    int start = pulseCnt;
    took = -1;
    for (int i = 0; i < maxWd; i++) begin
      @(negedge wdClk); #1;
      if (pulseCnt != start) begin took = i + 1; break; end
    end
  endtask

  task automatic drainQ(input int maxWd);
    for (int i = 0; i < maxWd && expQ.size() > 0; i++) begin
      @(negedge wdClk); #1;
    end
    chk("R4 expected intervals seen", expQ.size(), 0);
  endtask

  initial begin
    #3000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base, took;
    porN = 0; rstN = 0; cfgWr = 0; cfgWdata = '0; monArm = 0; kick = 0; causeClr = 0;
    repeat (5) @(negedge sysClk);
    porN = 1; rstN = 1;
    @(negedge sysClk);
    chk("R1 cfgQ", cfgQ, 0);
    chk("R1 monActive", monActive, 0);
    chk("R1 rstReq", rstReq, 0);
    chk("R1 causeFlag", causeFlag, 0);

    // R2: write without window ignored; unlock write itself changes nothing
    cfgWrite(5'b01011);
    chk("R2 write without window", cfgQ, 0);
    cfgWrite(5'b11000);
    chk("R2 unlock write leaves cfg", cfgQ, 0);
    // R3: commit on the 4th edge after unlock is taken
    repeat (3) @(negedge sysClk);
    cfgWrite(5'b00101);
    chk("R3 commit on 4th edge", cfgQ, 4'b0101);
    cfgWrite(5'b01110);
    chk("R3 window closed by commit", cfgQ, 4'b0101);
    cfgWrite(5'b11000);
    repeat (4) @(negedge sysClk);
    cfgWrite(5'b01110);
    chk("R3 commit on 5th edge ignored", cfgQ, 4'b0101);

    // R11: disabled and unarmed never expires
    repeat (100) @(negedge wdClk);
    chk("R11 no request while disabled", pulseCnt, 0);

    // R5: enable code 0, kick every 8 wd cycles
    cfgWrite(5'b11000);
    cfgWrite(5'b01000);
    chk("R3 enable committed", cfgQ, 4'b1000);
    repeat (30) begin
      pulseSys(kick);
      repeat (39) @(negedge sysClk);
    end
    chk("R5 kicks hold off expiry", pulseCnt, 0);

    // R4: free running timeout intervals
    waitPulse(40, took);
    chk("R4 expiry after kicks stop", took > 0, 1);
    expQ.push_back(16); expQ.push_back(16);
    drainQ(60);
    cfgWrite(5'b11000);
    cfgWrite(5'b01111);
    waitPulse(2200, took);
    expQ.push_back(2048);
    drainQ(2200);
    chk("R7 flag set by expiry", causeFlag, 1);

    // R7: survives system reset, cleared by causeClr
    @(negedge sysClk); rstN = 0;
    repeat (3) @(negedge sysClk); rstN = 1;
    @(negedge sysClk);
    chk("R7 flag survives rstN", causeFlag, 1);
    chk("R1 cfg cleared by rstN", cfgQ, 0);
    pulseSys(causeClr);
    repeat (10) @(negedge wdClk);
    @(negedge sysClk);
    chk("R7 flag cleared by causeClr", causeFlag, 0);

    // R8/R9: armed supervision
    pulseSys(monArm);
    chk("R8 monArm sets monActive", monActive, 1);
    cfgWrite(5'b11000);
    cfgWrite(5'b00000);
    chk("R9 disable write keeps armed", monActive, 1);
    base = pulseCnt;
    repeat (200) @(negedge wdClk);
    #1;
    chk("R8 no expiry while sysClk runs", pulseCnt - base, 0);

    // R10: stop the monitored clock
    sysRun = 0;
    waitPulse(60, took);
    chk("R10 expiry after sysClk stops", (took > 0 && took <= 24), 1);
    chk("R7 flag after clock loss", causeFlag, 1);
    #40 rstN = 0;
    #200 sysRun = 1;
    repeat (3) @(negedge sysClk);
    rstN = 1;
    @(negedge sysClk);
    chk("R9 rstN clears monActive", monActive, 0);
    chk("R7 flag kept over reset", causeFlag, 1);

    porN = 0;
    repeat (3) @(negedge sysClk);
    porN = 1;
    @(negedge sysClk);
    chk("R7 porN clears flag", causeFlag, 0);

    summary();
    $finish;
  end
endmodule